// File: doc/BRIEF.md
# Bridge Load Diagnostic Sequencer with Latched Fault Flag

This block decides when the output stage of a bridge-tied audio amplifier is tested, and it reacts to what the analog comparators report. Three load tests run as timed phases: each output against the supply rails, the two outputs against each other, and an open-load test. Each phase lasts a parameterised number of clock cycles. A test-phase select tells the analog side which comparator to arm, and the result is sampled on the last cycle of that phase. Over-current and over-temperature are watched on every cycle, whether or not a test is running.

A full sequence runs out of reset whatever the enable bit says, and the amplifier stays off until it completes. After that, a 0-to-1 change of the enable bit requests a full sequence. With the continuous bit set as well, the sequence repeats after a programmable idle gap. The repeated runs leave out the open-load phase. Any detected fault shuts the outputs off and stays latched. Each fault has an ignore-mask bit that keeps it off the active-low fault flag without weakening the protection. A 0-to-1 change of the clear bit releases the latch and returns the amplifier to the state its power-on bit asks for.

Top module: `ldiag_top`

## Requirements
- R1: Out of reset the block is busy and runs three phases of PHASE_CYC cycles each, ignoring the enable bit. The phases run in the order rail short (test_sel=1), bridge short (test_sel=2), open load (test_sel=3); test_sel is 0 whenever not busy. amp_en stays 0 during this sequence, and fault_n=1 and out_disable=0 are held in reset.
- R2: A 0-to-1 change of cfg_diag_clr during the power-up sequence aborts it. One edge later busy is 0 and amp_en follows cfg_power_on.
- R3: A 0-to-1 change of cfg_diag_en with cfg_diag_cont=0 runs exactly one full three-phase sequence of 3*PHASE_CYC busy cycles. Holding the enable bit high starts nothing more. A fall and a new rise runs it again.
- R4: An enable rise that arrives while a sequence is running is kept and started once that sequence ends.
- R5: With cfg_diag_cont=1 and cfg_diag_en=1, a finished sequence is followed by GAP_CYC idle cycles and then a repeat. The repeat has only the rail and bridge phases (2*PHASE_CYC cycles), so an open load present only during repeats is never reported.
- R6: Repetition stops when cfg_diag_cont or cfg_diag_en is cleared, when a fault is latched, or on a clear-bit rise.
- R7: cmp_over_curr or cmp_over_temp high on any clock edge latches a fault, even with no test running. From the next cycle out_disable=1 and amp_en=0.
- R8: A load comparator is sampled only on the last cycle of its own phase. A rail-short indication present at every other time is ignored.
- R9: A latched, unmasked fault drives fault_n low. fault_n stays low after the condition goes away and tests rerun, until a clear-bit rise.
- R10: Mask bit positions in cfg_ign_mask are: bit0 bridge short, bit1 open load, bit2 rail short, bit3 over-current, bit4 over-temperature. A set bit keeps fault_n high for that fault, but out_disable still goes to 1. Every test still runs whatever the mask says.
- R11: A clear-bit rise releases the fault latch and fault flag, so amp_en returns to cfg_power_on.
- R12: amp_en is 1 exactly when cfg_power_on=1, the power-up sequence is over, and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_power_on | input | 1 | Amplifier on request |
| cfg_diag_en | input | 1 | Diagnostic request, rising-edge sensitive |
| cfg_diag_cont | input | 1 | Repeat mode select |
| cfg_diag_clr | input | 1 | Fault clear / power-up abort, rising-edge sensitive |
| cfg_ign_mask | input | 5 | Per-fault flag ignore bits |
| cmp_rail_short | input | 1 | Comparator: output to rail short |
| cmp_out_short | input | 1 | Comparator: outputs shorted together |
| cmp_open_load | input | 1 | Comparator: no load |
| cmp_over_curr | input | 1 | Comparator: over-current |
| cmp_over_temp | input | 1 | Comparator: over-temperature |
| test_sel | output | 2 | Active test phase, 0 none |
| diag_busy | output | 1 | A test sequence is running |
| amp_en | output | 1 | Amplifier enable |
| out_disable | output | 1 | Protection shutdown of the outputs |
| fault_n | output | 1 | Active-low fault flag (open-drain level) |
| fault_latched | output | 1 | Fault latch state |

## Verification
The bench goes after the edge-triggered enable. A level-sensitive design would rerun the sequence forever while the bit stays high, and one that dropped a request arriving mid-sequence would never start the second run. The repeat mode is checked for its gap length and for skipping the open-load phase: a design that kept that phase would report a load removed after the first run. A rail-short indication is held outside its sample window, which exposes a sampler that is not tied to its phase. Random fault kinds are crossed with random masks to catch a mask that also blocks protection, or bits that are swapped. A flag that drops as soon as the fault goes away would fail the sticky check.

// File: rtl/ldiag_pkg.sv
package ldiag_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_GAP = 2'd2} seq_st_e;
  localparam int NUM_FLT = 5;
  localparam int NUM_PH  = 3;
  // fault bit positions (match the ignore mask)
  localparam int FB_BRIDGE = 0;
  localparam int FB_OPEN   = 1;
  localparam int FB_RAIL   = 2;
  localparam int FB_OCUR   = 3;
  localparam int FB_OTMP   = 4;
  // phase indices, test_sel = index + 1
  localparam int PH_RAIL   = 0;
  localparam int PH_BRIDGE = 1;
  localparam int PH_OPEN   = 2;
endpackage

// File: rtl/ldiag_edge.sv
module ldiag_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign rise[b] = lvl[b] & ~lvl_q[b];
    end
  endgenerate
endmodule

// File: rtl/ldiag_seq.sv
module ldiag_seq
  import ldiag_pkg::*;
#(
  parameter int PHASE_CYC = 8,
  parameter int GAP_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rise,
  input  logic              clr_evt,
  input  logic              cont_mode,
  input  logic              flt_latched,
  output logic              busy,
  output logic [1:0]        test_sel,
  output logic              init_act,
  output logic [NUM_PH-1:0] smp_stb
);
  localparam int CNT_MAX = (PHASE_CYC > GAP_CYC) ? PHASE_CYC : GAP_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] PH_LAST  = CW'(PHASE_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [1:0]    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          init_q, init_d;
  logic          wopen_q, wopen_d;
  logic          pend_q, pend_d;
  logic          phase_end, last_ph, gap_end, req;

  assign phase_end = (st_q == ST_RUN) && (cnt_q == PH_LAST);
  assign last_ph   = (ph_q == 2'(PH_OPEN)) || ((ph_q == 2'(PH_BRIDGE)) && !wopen_q);
  assign gap_end   = (st_q == ST_GAP) && (cnt_q == GAP_LAST);
  assign req       = pend_q | req_rise;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    wopen_d = wopen_q;
    pend_d  = pend_q | req_rise;
    if (clr_evt) begin
      st_d   = ST_IDLE;
      ph_d   = 2'd0;
      cnt_d  = '0;
      init_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req) begin
            st_d    = ST_RUN;
            ph_d    = 2'd0;
            cnt_d   = '0;
            wopen_d = 1'b1;
            pend_d  = 1'b0;
          end
        end
        ST_RUN: begin
          if (phase_end) begin
            cnt_d = '0;
            ph_d  = 2'd0;
            if (last_ph) begin
              init_d = 1'b0;
              if (cont_mode && !flt_latched && !init_q) st_d = ST_GAP;
              else                                      st_d = ST_IDLE;
            end else begin
              ph_d = ph_q + 2'd1;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_GAP: begin
          if (!cont_mode || flt_latched) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (gap_end) begin
            st_d    = ST_RUN;
            ph_d    = 2'd0;
            cnt_d   = '0;
            wopen_d = req;
            pend_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      ph_q    <= 2'd0;
      cnt_q   <= '0;
      init_q  <= 1'b1;
      wopen_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      wopen_q <= wopen_d;
      pend_q  <= pend_d;
    end
  end

  assign busy     = (st_q == ST_RUN);
  assign test_sel = busy ? (ph_q + 2'd1) : 2'd0;
  assign init_act = init_q;

  genvar k;
  generate
    for (k = 0; k < NUM_PH; k++) begin : g_stb
      assign smp_stb[k] = phase_end && (ph_q == 2'(k));
    end
  endgenerate
endmodule

// File: rtl/ldiag_flt.sv
module ldiag_flt
  import ldiag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_evt,
  input  logic [NUM_PH-1:0]  smp_stb,
  input  logic               cmp_rail,
  input  logic               cmp_bridge,
  input  logic               cmp_open,
  input  logic               cmp_ocur,
  input  logic               cmp_otmp,
  input  logic [NUM_FLT-1:0] ign_mask,
  output logic               latched,
  output logic               flag_low
);
  logic [NUM_FLT-1:0] det;
  logic latched_d, flag_d;

  assign det[FB_BRIDGE] = smp_stb[PH_BRIDGE] & cmp_bridge;
  assign det[FB_OPEN]   = smp_stb[PH_OPEN]   & cmp_open;
  assign det[FB_RAIL]   = smp_stb[PH_RAIL]   & cmp_rail;
  assign det[FB_OCUR]   = cmp_ocur;
  assign det[FB_OTMP]   = cmp_otmp;

  always_comb begin
    latched_d = latched | (|det);
    flag_d    = flag_low | (|(det & ~ign_mask));
    if (clr_evt) begin
      latched_d = 1'b0;
      flag_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      flag_low <= 1'b0;
    end else begin
      latched  <= latched_d;
      flag_low <= flag_d;
    end
  end
endmodule

// File: rtl/ldiag_top.sv
module ldiag_top
  import ldiag_pkg::*;
#(
  parameter int PHASE_CYC = 8,
  parameter int GAP_CYC   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_power_on,
  input  logic       cfg_diag_en,
  input  logic       cfg_diag_cont,
  input  logic       cfg_diag_clr,
  input  logic [4:0] cfg_ign_mask,
  input  logic       cmp_rail_short,
  input  logic       cmp_out_short,
  input  logic       cmp_open_load,
  input  logic       cmp_over_curr,
  input  logic       cmp_over_temp,
  output logic [1:0] test_sel,
  output logic       diag_busy,
  output logic       amp_en,
  output logic       out_disable,
  output logic       fault_n,
  output logic       fault_latched
);
  logic [1:0]        rise;
  logic              init_act, latched, flag_low;
  logic [NUM_PH-1:0] smp_stb;

  ldiag_edge #(.W(2)) u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .lvl ({cfg_diag_clr, cfg_diag_en}),
    .rise (rise)
  );

  ldiag_seq #(.PHASE_CYC(PHASE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .req_rise (rise[0]),
    .clr_evt (rise[1]),
    .cont_mode (cfg_diag_cont & cfg_diag_en),
    .flt_latched (latched),
    .busy (diag_busy),
    .test_sel (test_sel),
    .init_act (init_act),
    .smp_stb (smp_stb)
  );

  ldiag_flt u_flt (
    .clk (clk),
    .rst_n (rst_n),
    .clr_evt (rise[1]),
    .smp_stb (smp_stb),
    .cmp_rail (cmp_rail_short),
    .cmp_bridge (cmp_out_short),
    .cmp_open (cmp_open_load),
    .cmp_ocur (cmp_over_curr),
    .cmp_otmp (cmp_over_temp),
    .ign_mask (cfg_ign_mask),
    .latched (latched),
    .flag_low (flag_low)
  );

  assign amp_en        = cfg_power_on & ~init_act & ~latched;
  assign out_disable   = latched;
  assign fault_n       = ~flag_low;
  assign fault_latched = latched;
endmodule

// File: rtl/ldiag_chk.sv
module ldiag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_power_on,
  input logic       cfg_diag_clr,
  input logic [4:0] cfg_ign_mask,
  input logic       cmp_over_curr,
  input logic       cmp_over_temp,
  input logic [1:0] test_sel,
  input logic       diag_busy,
  input logic       amp_en,
  input logic       out_disable,
  input logic       fault_n
);
  logic clr_q, clr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= cfg_diag_clr;
  end
  assign clr_rise = cfg_diag_clr & ~clr_q;

  AST_SEL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_busy |-> (test_sel == 2'd0)); // R1
  AST_OCUR_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_over_curr && !clr_rise) |=> out_disable); // R7
  AST_OTMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_over_temp && !cfg_ign_mask[4] && !clr_rise) |=> !fault_n); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr_rise) |=> !fault_n); // R9
  AST_FLAG_HAS_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> out_disable); // R10
  AST_SHUTDOWN_NO_AMP: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> !amp_en); // R12
  AST_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_power_on |-> !amp_en); // R12
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise |=> !out_disable || $past(cmp_over_curr) == 1'b0); // R11
endmodule

bind ldiag_top ldiag_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .cfg_power_on (cfg_power_on),
  .cfg_diag_clr (cfg_diag_clr),
  .cfg_ign_mask (cfg_ign_mask),
  .cmp_over_curr (cmp_over_curr),
  .cmp_over_temp (cmp_over_temp),
  .test_sel (test_sel),
  .diag_busy (diag_busy),
  .amp_en (amp_en),
  .out_disable (out_disable),
  .fault_n (fault_n)
);

// File: tb/ldiag_top_tb_top.sv
module ldiag_top_tb_top;
  localparam int P   = 6;
  localparam int GAP = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_power_on, cfg_diag_en, cfg_diag_cont, cfg_diag_clr;
  logic [4:0] cfg_ign_mask;
  logic cmp_rail_short, cmp_out_short, cmp_open_load, cmp_over_curr, cmp_over_temp;
  logic [1:0] test_sel;
  logic diag_busy, amp_en, out_disable, fault_n, fault_latched;
  int kind;  // 0 none 1 rail 2 bridge 3 open 4 ocur 5 otmp 7 rail outside window
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign cmp_rail_short = (kind == 1) || ((kind == 7) && (test_sel != 2'd1));
  assign cmp_out_short  = (kind == 2);
  assign cmp_open_load  = (kind == 3);
  assign cmp_over_curr  = (kind == 4);
  assign cmp_over_temp  = (kind == 5);

  ldiag_top #(.PHASE_CYC(P), .GAP_CYC(GAP)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfg_power_on (cfg_power_on), .cfg_diag_en (cfg_diag_en),
    .cfg_diag_cont (cfg_diag_cont), .cfg_diag_clr (cfg_diag_clr),
    .cfg_ign_mask (cfg_ign_mask),
    .cmp_rail_short (cmp_rail_short), .cmp_out_short (cmp_out_short),
    .cmp_open_load (cmp_open_load), .cmp_over_curr (cmp_over_curr),
    .cmp_over_temp (cmp_over_temp),
    .test_sel (test_sel), .diag_busy (diag_busy), .amp_en (amp_en),
    .out_disable (out_disable), .fault_n (fault_n), .fault_latched (fault_latched)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for a run, returns busy cycles, open-phase cycles, amp_en-high cycles
  task automatic wait_run(output int nb, output int no, output int na);
    int t = 0;
    nb = 0; no = 0; na = 0;
    while (!diag_busy && t < 500) begin tick(); t++; end
    while (diag_busy && nb < 500) begin
      nb++;
      if (test_sel == 2'd3) no++;
      if (amp_en) na++;
      tick();
    end
  endtask

  task automatic count_idle(output int g);
    g = 0;
    while (!diag_busy && g < 500) begin g++; tick(); end
  endtask

  task automatic busy_in(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin if (diag_busy) c++; tick(); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic clear_pulse();
    cfg_diag_clr = 1'b1; tick();
    cfg_diag_clr = 1'b0;
  endtask

  function automatic int flt_bit(input int k);
    case (k)
      1: return 2;
      2: return 0;
      3: return 1;
      4: return 3;
      5: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_fault_n(input int k, input logic [4:0] m);
    if (flt_bit(k) < 0) return 1;
    return m[flt_bit(k)] ? 1 : 0;
  endfunction

  initial begin
    int nb, no, na, g, c;
    void'($urandom(32'd5150));
    kind = 0;
    cfg_power_on = 1'b1; cfg_diag_en = 1'b0; cfg_diag_cont = 1'b0;
    cfg_diag_clr = 1'b0; cfg_ign_mask = 5'h00;
    rst_n = 1'b0;
    tick(3);
    chk("R1 busy in reset", diag_busy, 1);
    chk("R1 amp_en in reset", amp_en, 0);
    chk("R1 fault_n in reset", fault_n, 1);
    chk("R1 out_disable in reset", out_disable, 0);
    rst_n = 1'b1;
    wait_run(nb, no, na);
    chk("R1 power-up length", nb, 3*P);
    chk("R1 open phase length", no, P);
    chk("R1 amp off during power-up", na, 0);
    chk("R1 amp on after power-up", amp_en, 1);
    chk("R1 test_sel idle", test_sel, 0);

    // R3 one-shot
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    chk("R3 one-shot length", nb, 3*P);
    busy_in(3*GAP, c);
    chk("R3 no rerun while held", c, 0);
    cfg_diag_en = 1'b0; tick();
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    chk("R3 rerun after toggle", nb, 3*P);
    cfg_diag_en = 1'b0;

    // R4 request during power-up is kept
    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    chk("R4 power-up length", nb, 3*P);
    wait_run(nb, no, na);
    chk("R4 pending run", nb, 3*P);
    cfg_diag_en = 1'b0;

    // R2 abort power-up
    do_reset();
    tick(2);
    cfg_diag_clr = 1'b1; tick();
    chk("R2 abort busy", diag_busy, 0);
    chk("R2 abort amp_en", amp_en, 1);
    cfg_diag_clr = 1'b0;

    // R12 power off
    cfg_power_on = 1'b0; tick();
    chk("R12 power off", amp_en, 0);
    cfg_power_on = 1'b1; tick();
    chk("R12 power on", amp_en, 1);

    // R5 continuous
    cfg_diag_cont = 1'b1; tick();
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    chk("R5 first run", nb, 3*P);
    count_idle(g);
    chk("R5 gap", g, GAP);
    wait_run(nb, no, na);
    chk("R5 repeat length", nb, 2*P);
    chk("R5 repeat no open", no, 0);
    kind = 3;
    wait_run(nb, no, na);
    chk("R5 repeat2 length", nb, 2*P);
    chk("R5 open not reported", fault_n, 1);
    chk("R5 open not latched", out_disable, 0);
    cfg_diag_cont = 1'b0;
    busy_in(2*GAP, c);
    chk("R6 stop on cont clear", c, 0);
    kind = 0; cfg_diag_en = 1'b0; tick();

    // R6 stop on fault, R9 flag
    cfg_diag_cont = 1'b1; kind = 1; tick();
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    chk("R6 faulting run length", nb, 3*P);
    busy_in(2*GAP, c);
    chk("R6 stop on fault", c, 0);
    chk("R9 flag low on rail", fault_n, 0);
    chk("R7 disable on rail", out_disable, 1);
    chk("R12 amp off on fault", amp_en, 0);
    cfg_diag_cont = 1'b0; cfg_diag_en = 1'b0; kind = 0; tick();
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    tick();
    chk("R9 flag stays low", fault_n, 0);
    cfg_diag_en = 1'b0;
    clear_pulse();
    chk("R11 flag released", fault_n, 1);
    chk("R11 disable released", out_disable, 0);
    chk("R11 amp restored", amp_en, 1);

    // R6 stop on clear
    cfg_diag_cont = 1'b1; tick();
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    clear_pulse();
    busy_in(2*GAP, c);
    chk("R6 stop on clear", c, 0);
    cfg_diag_cont = 1'b0; cfg_diag_en = 1'b0; tick();

    // R8 rail indication outside window
    kind = 7; tick();
    cfg_diag_en = 1'b1;
    wait_run(nb, no, na);
    tick();
    chk("R8 outside window ignored", out_disable, 0);
    chk("R8 flag untouched", fault_n, 1);
    kind = 0; cfg_diag_en = 1'b0; tick();

    // R7 over-current without diagnostics
    kind = 4; tick();
    chk("R7 ocur disables", out_disable, 1);
    chk("R7 ocur amp off", amp_en, 0);
    kind = 0; clear_pulse();
    chk("R11 clear after ocur", out_disable, 0);

    // random faults x masks (R10 R9 R7 R11)
    for (int it = 0; it < 24; it++) begin
      int k;
      logic pw;
      logic [4:0] m;
      k  = $urandom_range(0, 5);
      m  = 5'($urandom);
      pw = 1'($urandom);
      cfg_ign_mask = m; cfg_power_on = pw; kind = k;
      tick();
      cfg_diag_en = 1'b1;
      wait_run(nb, no, na);
      tick();
      chk("R10 run length", nb, 3*P);
      chk("R10 disable", out_disable, (k != 0) ? 1 : 0);
      chk("R10 flag", fault_n, exp_fault_n(k, m));
      chk("R12 amp_en", amp_en, (pw && k == 0) ? 1 : 0);
      kind = 0; cfg_diag_en = 1'b0;
      clear_pulse();
      chk("R11 release", out_disable, 0);
      chk("R11 amp back", amp_en, pw ? 1 : 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule